// File: doc/BRIEF.md
# Dual Pipelined Sobel Gradient Engine

This block computes an approximate Sobel edge strength for a stream of 3x3 gray-scale neighbourhoods. A new window can be presented on every clock. Two matching datapaths work on the same window at the same time. One forms the horizontal component and the other forms the vertical component. The absolute values of the two components are added, halved and compared with a threshold, which gives a gradient byte and an edge flag.

The datapath has four register stages. Stage one forms the pair sums and the doubled centre taps. Stage two forms the weighted column and row sums and divides each by four. Stage three takes the two differences and their magnitudes. Stage four adds the magnitudes, halves the sum and compares it with the threshold. Every division is done by bit selection, so no register exists only to scale a value. The threshold is carried down the pipe with its window, which lets the threshold change from one window to the next. Line buffering and video timing belong to the logic around this block.

Pixel k of the window sits at bits [k*8 +: 8] of `in_win`, with k = 3*row + col. Row 0 is the top row and col 0 is the left column.

Top module: `sobel_grad_pipe`

## Requirements
- R1: A synchronous reset forces `out_valid` low on the clock after it is sampled, and keeps it low for as long as the reset stays high.
- R2: A window presented with `in_valid` high in cycle k produces `out_valid` high in cycle k+4. Windows on consecutive cycles produce results on consecutive cycles.
- R3: With P(r,c) the pixel at row r and column c, the quarter sums are computed separately and truncated. The horizontal component is gx = floor((P02+2*P12+P22)/4) - floor((P00+2*P10+P20)/4). The vertical component is gy = floor((P20+2*P21+P22)/4) - floor((P00+2*P01+P02)/4). `out_grad` = floor((|gx|+|gy|)/2).
- R4: A window that changes only from left to right drives only gx. A window that changes only from top to bottom drives only gy. Both components come from the same window in the same pass.
- R5: `out_edge` is 1 exactly when `out_grad` >= the `in_thr` value that was sampled together with the same window.
- R6: A window of nine equal pixels gives `out_grad` = 0, whatever the pixel value.
- R7: Full-scale pixel values give the exact result with no wrap. For example, the window 0,0,255 / 0,0,255 / 255,255,255 gives 192.
- R8: A cycle with `in_valid` low produces a cycle with `out_valid` low four cycles later, even when valid windows surround it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Window strobe |
| in_win | input | 72 | Nine 8-bit pixels, row-major, pixel 0 in the low bits |
| in_thr | input | 8 | Edge threshold that goes with this window |
| out_valid | output | 1 | Result strobe |
| out_grad | output | 8 | Approximate gradient magnitude |
| out_edge | output | 1 | Gradient is at or above the threshold |

## Verification
The bench targets rounding. It uses windows whose weighted sums are not multiples of four. A design that subtracted before dividing, or that rounded instead of truncating, would give a different byte for these windows. Full-scale windows catch a stage that drops a carry bit and wraps 192 back to a small value. Threshold values equal to the gradient and one above it expose a strict-versus-inclusive compare, and a threshold that changes on every cycle exposes a threshold that is not carried down the pipe with its window. Random traffic with bubbles, followed by a reset while the pipe is full, catches valid bits that slip a cycle or survive the reset.

// File: rtl/sobel_grad_pipe.sv
module sobel_grad_pipe #(
  parameter int PIX_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [9*PIX_W-1:0]   in_win,
  input  logic [PIX_W-1:0]     in_thr,
  output logic                 out_valid,
  output logic [PIX_W-1:0]     out_grad,
  output logic                 out_edge
);
  localparam int SW = PIX_W + 1;
  localparam int WW = PIX_W + 2;

  function automatic logic [PIX_W-1:0] px(input logic [9*PIX_W-1:0] w, input int k);
    return w[k*PIX_W +: PIX_W];
  endfunction

  // stage 1: pair sums and doubled centre taps
  logic          v1;
  logic [PIX_W-1:0] thr1;
  logic [SW-1:0] xr_p, xr_d, xl_p, xl_d, yb_p, yb_d, yt_p, yt_d;

  always_ff @(posedge clk) begin
    if (rst) v1 <= 1'b0;
    else     v1 <= in_valid;
    thr1 <= in_thr;
    xr_p <= SW'(px(in_win, 2)) + SW'(px(in_win, 8));
    xr_d <= {px(in_win, 5), 1'b0};
    xl_p <= SW'(px(in_win, 0)) + SW'(px(in_win, 6));
    xl_d <= {px(in_win, 3), 1'b0};
    yb_p <= SW'(px(in_win, 6)) + SW'(px(in_win, 8));
    yb_d <= {px(in_win, 7), 1'b0};
    yt_p <= SW'(px(in_win, 0)) + SW'(px(in_win, 2));
    yt_d <= {px(in_win, 1), 1'b0};
  end

  // stage 2: weighted sums, quarter by bit selection
  logic [WW-1:0] xr_w, xl_w, yb_w, yt_w;
  assign xr_w = WW'(xr_p) + WW'(xr_d);
  assign xl_w = WW'(xl_p) + WW'(xl_d);
  assign yb_w = WW'(yb_p) + WW'(yb_d);
  assign yt_w = WW'(yt_p) + WW'(yt_d);

  logic          v2;
  logic [PIX_W-1:0] thr2, xr_q, xl_q, yb_q, yt_q;

  always_ff @(posedge clk) begin
    if (rst) v2 <= 1'b0;
    else     v2 <= v1;
    thr2 <= thr1;
    xr_q <= xr_w[WW-1:2];
    xl_q <= xl_w[WW-1:2];
    yb_q <= yb_w[WW-1:2];
    yt_q <= yt_w[WW-1:2];
  end

  // stage 3: magnitudes of both components
  logic          v3;
  logic [PIX_W-1:0] thr3, ax, ay;

  always_ff @(posedge clk) begin
    if (rst) v3 <= 1'b0;
    else     v3 <= v2;
    thr3 <= thr2;
    ax   <= (xr_q >= xl_q) ? xr_q - xl_q : xl_q - xr_q;
    ay   <= (yb_q >= yt_q) ? yb_q - yt_q : yt_q - yb_q;
  end

  // stage 4: half sum and threshold
  logic [SW-1:0]    mag_sum;
  logic [PIX_W-1:0] mag_half;
  assign mag_sum  = SW'(ax) + SW'(ay);
  assign mag_half = mag_sum[SW-1:1];

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= v3;
    out_grad <= mag_half;
    out_edge <= (mag_half >= thr3);
  end

  // cycles since reset, saturating, for the history-based checks
  logic [2:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst)                  since_rst <= '0;
    else if (since_rst != 3'd4) since_rst <= since_rst + 3'd1;
  end

  logic in_flat;
  always_comb begin
    in_flat = 1'b1;
    for (int k = 1; k < 9; k++)
      if (px(in_win, k) != px(in_win, 0)) in_flat = 1'b0;
  end

  AST_RESET_CLEAR: assert property (@(posedge clk) $past(rst) |-> !out_valid); // R1
  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 3'd4) |-> (out_valid == $past(in_valid, 4))); // R2
  AST_EDGE_COMPARE: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 3'd4 && out_valid) |-> (out_edge == (out_grad >= $past(in_thr, 4)))); // R5
  AST_FLAT_ZERO: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 3'd4 && $past(in_valid && in_flat, 4)) |-> (out_grad == '0)); // R6
endmodule

// File: tb/sobel_grad_pipe_bench.sv
module sobel_grad_pipe_bench;
  localparam int CLK_PERIOD = 10;
  localparam int PW = 8;
  localparam int NCYC = 1024;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [9*PW-1:0] in_win = '0;
  logic [PW-1:0] in_thr = '0;
  logic out_valid;
  logic [PW-1:0] out_grad;
  logic out_edge;

  sobel_grad_pipe #(.PIX_W(PW)) u_sobel_grad_pipe (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_win(in_win), .in_thr(in_thr),
    .out_valid(out_valid), .out_grad(out_grad), .out_edge(out_edge)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  int t = 0;
  bit    hv [0:NCYC-1];
  int    hg [0:NCYC-1];
  bit    he [0:NCYC-1];
  string ht [0:NCYC-1];

  function automatic int iabs(int a);
    return (a < 0) ? -a : a;
  endfunction

  function automatic int model_grad(logic [9*PW-1:0] w);
    int p [9];
    int gx, gy;
    for (int k = 0; k < 9; k++) p[k] = int'(w[k*PW +: PW]);
    gx = (p[2] + 2*p[5] + p[8]) / 4 - (p[0] + 2*p[3] + p[6]) / 4;
    gy = (p[6] + 2*p[7] + p[8]) / 4 - (p[0] + 2*p[1] + p[2]) / 4;
    return (iabs(gx) + iabs(gy)) / 2;
  endfunction

  function automatic logic [9*PW-1:0] mk(int a, int b, int c, int d, int e, int f, int g, int h, int i);
    int v [9];
    logic [9*PW-1:0] w;
    v = '{a, b, c, d, e, f, g, h, i};
    for (int k = 0; k < 9; k++) w[k*PW +: PW] = PW'(v[k]);
    return w;
  endfunction

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s cycle %0d: actual %0d expected %0d", tag, t, act, exp);
    end
  endtask

  task automatic step(bit v, logic [9*PW-1:0] w, int thr, string tag);
    @(negedge clk);
    if (t >= 4 && hv[t-4]) begin
      check(ht[t-4], int'(out_valid), 1);
      check(ht[t-4], int'(out_grad), hg[t-4]);
      check(ht[t-4], int'(out_edge), int'(he[t-4]));
    end else begin
      check((t >= 4) ? "R8" : "R2", int'(out_valid), 0);
    end
    in_valid = v;
    in_win = w;
    in_thr = PW'(thr);
    hv[t] = v;
    hg[t] = model_grad(w);
    he[t] = (model_grad(w) >= thr);
    ht[t] = tag;
    t++;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", int'(out_valid), 0);
    rst = 1'b0;

    // R6 flat windows
    step(1, mk(0,0,0,0,0,0,0,0,0), 0, "R6");
    step(1, mk(77,77,77,77,77,77,77,77,77), 1, "R6");
    step(1, mk(255,255,255,255,255,255,255,255,255), 0, "R6");
    // R4 single-direction steps
    step(1, mk(0,0,100,0,0,100,0,0,100), 50, "R4");
    step(1, mk(0,0,100,0,0,100,0,0,100), 51, "R5");
    step(1, mk(10,10,10,10,10,10,200,200,200), 0, "R4");
    step(1, mk(200,200,200,10,10,10,10,10,10), 255, "R4");
    // R3 truncation of separate quarter sums
    step(1, mk(0,0,3,0,0,3,0,0,2), 1, "R3");
    step(1, mk(1,2,3,4,5,6,7,8,9), 2, "R3");
    step(1, mk(3,1,0,1,0,2,0,3,3), 0, "R3");
    // R7 full scale
    step(1, mk(0,0,255,0,0,255,255,255,255), 192, "R7");
    step(1, mk(255,255,255,255,0,0,255,0,0), 193, "R7");
    step(1, mk(0,0,255,0,0,255,0,0,255), 127, "R7");
    // R8 bubbles between valid windows
    step(0, mk(9,9,9,9,9,9,9,9,9), 0, "R8");
    step(1, mk(0,50,100,0,50,100,0,50,100), 10, "R8");
    step(0, mk(0,0,0,0,0,0,0,0,0), 0, "R8");
    // R2/R5 random back-to-back traffic with changing thresholds
    for (int n = 0; n < 400; n++) begin
      logic [9*PW-1:0] w;
      for (int k = 0; k < 9*PW; k += 32) w[k +: 32] = $urandom;
      step(($urandom % 5) != 0, w, int'($urandom % 160), (n % 2) ? "R2" : "R5");
    end
    for (int n = 0; n < 5; n++) step(0, '0, 0, "R8");

    // R1 reset with a full pipe
    for (int n = 0; n < 4; n++) step(1, mk(0,0,255,0,0,255,0,0,255), 0, "R1");
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1", int'(out_valid), 0);
    @(negedge clk);
    check("R1", int'(out_valid), 0);
    rst = 1'b0;
    in_valid = 1'b0;
    @(negedge clk);
    check("R1", int'(out_valid), 0);

    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule